// File: doc/BRIEF.md
# Obfuscated Source-Route Header Builder

This block sits in the network interface of a two-dimensional mesh. When a packet is about to be injected, it builds the routing field that travels in the header flit. That field is a list of per-hop codes rather than a destination address. Given the source coordinates and the destination node number, the block walks the dimension-ordered route one hop per clock. It moves along X until the column matches, then along Y until the row matches, and finishes with a Local hop at the destination switch.

For every hop, the block finds the switch that will consume that slot. It then takes the code that switch expects for the chosen direction from that switch's private inverse table. The tables for all switches live in a register array that a configuration port writes. After the Local hop, the remaining slots are filled with pseudo-random pad codes, so every header has the same number of slots whatever the hop count. A busy flag holds off new requests until the one-cycle done strobe marks the finished field.

Directions are numbered East = 0 (x + 1), West = 1 (x − 1), North = 2 (y + 1), South = 3 (y − 1) and Local = 4. Node number = y · MESH_X + x. Slot k of the path field occupies bits [k·CODE_W +: CODE_W], with slot 0 as the first hop.

Top module: `pathhdr_builder`

## Requirements
- R1: After reset, `busy`, `done` and `path_out` are all zero. Every switch table holds the identity mapping, so the code for direction d is d.
- R2: A request is taken on a clock edge where `req_valid` is high and `busy` is low, and `busy` is high from the next cycle. Requests presented while `busy` is high are ignored and leave the result of the request in progress unchanged. While idle with no request, `path_out` holds its value.
- R3: Route slots list every X hop before any Y hop, followed by one Local hop. Each slot holds `table[node][dir]`, where node is the switch at which that hop is taken.
- R4: A corner-to-corner route in the 8x8 mesh fills all 15 slots: 7 X hops, 7 Y hops and Local. The block stays busy for exactly PATH_SLOTS cycles.
- R5: When the destination equals the source, slot 0 holds the source switch's Local code, and every later slot is a pad.
- R6: Each slot after the Local hop holds `s mod 5`, where s is a 5-bit LFSR (s ← {s[3:0], s[4]^s[2]}) that starts at LFSR_SEED on reset. The LFSR steps once per pad slot and keeps its state across requests.
- R7: `done` is a one-cycle pulse, raised PATH_SLOTS cycles after the accepting edge, in the same cycle that `busy` falls.
- R8: A configuration write replaces the whole table of `cfg_node`. In `cfg_codes`, bits [d·CODE_W +: CODE_W] hold the code for direction d. The write changes the codes of later requests but not a finished `path_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write enable |
| cfg_node | input | NODE_W (6) | Switch whose table is written |
| cfg_codes | input | N_DIRS·CODE_W (15) | New table, one code per direction |
| req_valid | input | 1 | Build request |
| req_src_x | input | XW (3) | Source column |
| req_src_y | input | YW (3) | Source row |
| req_dst_node | input | NODE_W (6) | Destination node number |
| busy | output | 1 | Build in progress; requests ignored |
| done | output | 1 | One-cycle strobe: path_out complete |
| path_out | output | PATH_SLOTS·CODE_W (45) | Slot-coded route field |

## Verification
The bench uses the default 8x8 mesh, 3-bit codes and PATH_SLOTS = 15, with seed 5'h1F. With these values a corner-to-corner route fills the field exactly, with no slack, while a source-equals-destination request exposes fourteen consecutive pad codes of the LFSR sequence. The tables of a whole row and column are rewritten with non-identity permutations, so route codes only match when each hop reads the table of the switch actually being passed. Routes run in every direction, including pure-Y routes, and a request is attempted while busy.

// File: rtl/pathhdr_pkg.sv
package pathhdr_pkg;

   // Direction numbering; the index into each switch's inverse table.
   typedef enum logic [2:0] {
      DIR_EAST  = 3'd0,
      DIR_WEST  = 3'd1,
      DIR_NORTH = 3'd2,
      DIR_SOUTH = 3'd3,
      DIR_LOCAL = 3'd4
   } hop_dir_e;

   localparam int N_DIRS = 5;
   localparam int LFSR_W = 5;

endpackage

// File: rtl/pathhdr_code_tables.sv
module pathhdr_code_tables
   import pathhdr_pkg::*;
#(
   parameter int NODES  = 64,
   parameter int CODE_W = 3,
   localparam int NODE_W = $clog2(NODES),
   localparam int TBL_W  = N_DIRS * CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [NODE_W-1:0] cfg_node,
   input  logic [TBL_W-1:0]  cfg_codes,
   input  logic [NODE_W-1:0] rd_node,
   input  hop_dir_e          rd_dir,
   output logic [CODE_W-1:0] rd_code
);

   function automatic logic [TBL_W-1:0] ident_codes();
      logic [TBL_W-1:0] r;
      r = '0;
      for (int d = 0; d < N_DIRS; d++) begin
         r[d*CODE_W +: CODE_W] = CODE_W'(d);
      end
      return r;
   endfunction

   localparam logic [TBL_W-1:0] IDENT = ident_codes();

   logic [TBL_W-1:0] tbl [NODES];

   for (genvar n = 0; n < NODES; n++) begin : g_node
      logic [TBL_W-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row_q <= IDENT;
         end else if (cfg_we && (cfg_node == NODE_W'(n))) begin
            row_q <= cfg_codes;
         end
      end
      assign tbl[n] = row_q;
   end

   logic [TBL_W-1:0] sel_row;
   always_comb begin
      sel_row = tbl[rd_node];
      rd_code = sel_row[int'(rd_dir)*CODE_W +: CODE_W];
   end

endmodule

// File: rtl/pathhdr_route_step.sv
module pathhdr_route_step
   import pathhdr_pkg::*;
#(
   parameter int XW = 3,
   parameter int YW = 3
) (
   input  logic [XW-1:0] cur_x,
   input  logic [YW-1:0] cur_y,
   input  logic [XW-1:0] dst_x,
   input  logic [YW-1:0] dst_y,
   input  logic          local_sent,
   output hop_dir_e      dir,
   output logic [XW-1:0] nxt_x,
   output logic [YW-1:0] nxt_y,
   output logic          route_hop
);

   // X first, then Y, then one Local hop; anything after is padding.
   always_comb begin
      dir       = DIR_LOCAL;
      nxt_x     = cur_x;
      nxt_y     = cur_y;
      route_hop = 1'b0;
      if (cur_x < dst_x) begin
         dir = DIR_EAST;  nxt_x = cur_x + XW'(1); route_hop = 1'b1;
      end else if (cur_x > dst_x) begin
         dir = DIR_WEST;  nxt_x = cur_x - XW'(1); route_hop = 1'b1;
      end else if (cur_y < dst_y) begin
         dir = DIR_NORTH; nxt_y = cur_y + YW'(1); route_hop = 1'b1;
      end else if (cur_y > dst_y) begin
         dir = DIR_SOUTH; nxt_y = cur_y - YW'(1); route_hop = 1'b1;
      end else if (!local_sent) begin
         dir = DIR_LOCAL; route_hop = 1'b1;
      end
   end

endmodule

// File: rtl/pathhdr_pad_lfsr.sv
module pathhdr_pad_lfsr
   import pathhdr_pkg::*;
#(
   parameter int              CODE_W = 3,
   parameter logic [LFSR_W-1:0] SEED = 5'h1F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   output logic [CODE_W-1:0] pad_code
);

   logic [LFSR_W-1:0] st_q;
   logic              fb;

   assign fb       = st_q[4] ^ st_q[2];
   assign pad_code = CODE_W'(st_q % LFSR_W'(N_DIRS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= SEED;
      end else if (step) begin
         st_q <= {st_q[LFSR_W-2:0], fb};
      end
   end

endmodule

// File: rtl/pathhdr_builder.sv
module pathhdr_builder
   import pathhdr_pkg::*;
#(
   parameter int              MESH_X     = 8,
   parameter int              MESH_Y     = 8,
   parameter int              CODE_W     = 3,
   parameter int              PATH_SLOTS = MESH_X + MESH_Y - 1,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 5'h1F,
   localparam int NODES  = MESH_X * MESH_Y,
   localparam int NODE_W = $clog2(NODES),
   localparam int XW     = $clog2(MESH_X),
   localparam int YW     = $clog2(MESH_Y),
   localparam int TBL_W  = N_DIRS * CODE_W,
   localparam int PATH_W = PATH_SLOTS * CODE_W,
   localparam int SLOT_W = $clog2(PATH_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [NODE_W-1:0] cfg_node,
   input  logic [TBL_W-1:0]  cfg_codes,
   input  logic              req_valid,
   input  logic [XW-1:0]     req_src_x,
   input  logic [YW-1:0]     req_src_y,
   input  logic [NODE_W-1:0] req_dst_node,
   output logic              busy,
   output logic              done,
   output logic [PATH_W-1:0] path_out
);

   // Elaboration-time parameter checks
   if (MESH_X < 2 || MESH_Y < 2) begin : g_bad_mesh
      $error("mesh needs at least two columns and two rows");
   end
   if ((1 << CODE_W) < N_DIRS) begin : g_bad_code
      $error("CODE_W too narrow for all directions");
   end
   if (PATH_SLOTS < MESH_X + MESH_Y - 1) begin : g_bad_slots
      $error("PATH_SLOTS cannot hold the longest route");
   end
   if (LFSR_SEED == '0) begin : g_bad_seed
      $error("LFSR_SEED must be nonzero");
   end

   logic              busy_q, done_q, local_q;
   logic [SLOT_W-1:0] slot_q;
   logic [XW-1:0]     cur_x_q, dst_x_q, nxt_x;
   logic [YW-1:0]     cur_y_q, dst_y_q, nxt_y;
   logic [PATH_W-1:0] path_q;
   hop_dir_e          hop_dir;
   logic              route_hop;
   logic [CODE_W-1:0] tbl_code, pad_code, hop_code;
   logic [NODE_W-1:0] cur_node;

   assign cur_node = NODE_W'(cur_y_q) * NODE_W'(MESH_X) + NODE_W'(cur_x_q);

   pathhdr_route_step #(.XW(XW), .YW(YW)) u_step (
      .cur_x      (cur_x_q),
      .cur_y      (cur_y_q),
      .dst_x      (dst_x_q),
      .dst_y      (dst_y_q),
      .local_sent (local_q),
      .dir        (hop_dir),
      .nxt_x      (nxt_x),
      .nxt_y      (nxt_y),
      .route_hop  (route_hop)
   );

   pathhdr_code_tables #(.NODES(NODES), .CODE_W(CODE_W)) u_tables (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_node  (cfg_node),
      .cfg_codes (cfg_codes),
      .rd_node   (cur_node),
      .rd_dir    (hop_dir),
      .rd_code   (tbl_code)
   );

   pathhdr_pad_lfsr #(.CODE_W(CODE_W), .SEED(LFSR_SEED)) u_pad (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (busy_q && !route_hop),
      .pad_code (pad_code)
   );

   assign hop_code = route_hop ? tbl_code : pad_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         local_q <= 1'b0;
         slot_q  <= '0;
         cur_x_q <= '0;
         cur_y_q <= '0;
         dst_x_q <= '0;
         dst_y_q <= '0;
         path_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (req_valid) begin
               busy_q  <= 1'b1;
               local_q <= 1'b0;
               slot_q  <= '0;
               cur_x_q <= req_src_x;
               cur_y_q <= req_src_y;
               dst_x_q <= XW'(req_dst_node % NODE_W'(MESH_X));
               dst_y_q <= YW'(req_dst_node / NODE_W'(MESH_X));
               path_q  <= '0;
            end
         end else begin
            path_q[int'(slot_q)*CODE_W +: CODE_W] <= hop_code;
            cur_x_q <= nxt_x;
            cur_y_q <= nxt_y;
            if (route_hop && hop_dir == DIR_LOCAL) begin
               local_q <= 1'b1;
            end
            if (slot_q == SLOT_W'(PATH_SLOTS - 1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               slot_q <= slot_q + SLOT_W'(1);
            end
         end
      end
   end

   assign busy     = busy_q;
   assign done     = done_q;
   assign path_out = path_q;

endmodule

// File: rtl/pathhdr_checker.sv
module pathhdr_checker #(
   parameter int PATH_SLOTS = 15,
   parameter int PATH_W     = 45
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic [PATH_W-1:0] path_out
);

   int run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= 0;
      else if (busy) run_q <= run_q + 1;
      else           run_q <= 0;
   end

   always @(posedge clk) begin
      if (rst_n) begin
         assert_busy_window_R4: assert (run_q <= PATH_SLOTS)
            else $error("busy held beyond PATH_SLOTS cycles");
      end
   end

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |=> $stable(path_out));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_done_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_q == PATH_SLOTS));

endmodule

bind pathhdr_builder pathhdr_checker #(
   .PATH_SLOTS (PATH_SLOTS),
   .PATH_W     (PATH_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .path_out  (path_out)
);

// File: tb/pathhdr_builder_tb.sv
module pathhdr_builder_tb;

   localparam int MX = 8, MY = 8, CW = 3, SLOTS = 15;
   localparam int PW = SLOTS * CW;
   localparam logic [4:0] SEED = 5'h1F;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [5:0]    cfg_node = '0;
   logic [14:0]   cfg_codes = '0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_src_x = '0, req_src_y = '0;
   logic [5:0]    req_dst_node = '0;
   logic          busy, done;
   logic [PW-1:0] path_out;

   pathhdr_builder #(.MESH_X(MX), .MESH_Y(MY), .CODE_W(CW), .PATH_SLOTS(SLOTS),
                     .LFSR_SEED(SEED)) u_dut (.*);

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc++;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   logic [PW-1:0] exp_q[$];
   int            nr_q[$];
   int            acc_q[$];
   string         tag_q[$];

   int         tbl [64][5];
   logic [4:0] lf;

   task automatic check(input bit ok, input string tag, input logic [PW-1:0] got,
                        input logic [PW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Reference model built from the requirement text.
   task automatic compute_exp(input int sx, input int sy, input int dst,
                              output logic [PW-1:0] p, output int nr);
      int x, y, dx, dy, s, d;
      x = sx; y = sy; dx = dst % MX; dy = dst / MX; s = 0; p = '0;
      while (x != dx || y != dy) begin
         if (x < dx)      begin d = 0; end
         else if (x > dx) begin d = 1; end
         else if (y < dy) begin d = 2; end
         else             begin d = 3; end
         p[s*CW +: CW] = CW'(tbl[y*MX + x][d]);
         if (d == 0) x++; else if (d == 1) x--; else if (d == 2) y++; else y--;
         s++;
      end
      p[s*CW +: CW] = CW'(tbl[y*MX + x][4]);
      s++;
      nr = s;
      while (s < SLOTS) begin
         p[s*CW +: CW] = CW'(lf % 5);
         lf = {lf[3:0], lf[4] ^ lf[2]};
         s++;
      end
   endtask

   task automatic send(input int sx, input int sy, input int dst, input string tag);
      logic [PW-1:0] p;
      int nr;
      while (busy) @(negedge clk);
      compute_exp(sx, sy, dst, p, nr);
      exp_q.push_back(p); nr_q.push_back(nr); tag_q.push_back(tag);
      req_valid = 1'b1; req_src_x = 3'(sx); req_src_y = 3'(sy); req_dst_node = 6'(dst);
      @(negedge clk);
      req_valid = 1'b0;
      acc_q.push_back(cyc);
      check(busy === 1'b1, "R2 busy after accept", PW'(busy), PW'(1));
   endtask

   task automatic cfg_write(input int node);
      @(negedge clk);
      cfg_we = 1'b1; cfg_node = 6'(node);
      for (int d = 0; d < 5; d++) begin
         tbl[node][d] = (2 * d + node) % 5;
         cfg_codes[d*CW +: CW] = CW'(tbl[node][d]);
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Monitor / scoreboard
   bit prev_done = 1'b0;
   always @(negedge clk) begin
      if (prev_done) check(done === 1'b0, "R7 done one cycle", PW'(done), PW'(0));
      prev_done = (done === 1'b1);
      if (done === 1'b1) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected done", PW'(1), PW'(0));
         end else begin
            logic [PW-1:0] e;
            int nr, a;
            bit rok, pok;
            string t;
            e = exp_q.pop_front(); nr = nr_q.pop_front(); a = acc_q.pop_front();
            t = tag_q.pop_front();
            rok = 1'b1; pok = 1'b1;
            for (int s = 0; s < SLOTS; s++) begin
               if (path_out[s*CW +: CW] !== e[s*CW +: CW]) begin
                  if (s < nr) rok = 1'b0; else pok = 1'b0;
               end
            end
            check(rok, t, path_out, e);
            check(pok, "R6 pad codes", path_out, e);
            check(cyc - a == SLOTS, "R7 done latency", PW'(cyc - a), PW'(SLOTS));
            check(busy === 1'b0, "R7 busy low at done", PW'(busy), PW'(0));
         end
      end
   end

   initial begin
      logic [PW-1:0] held;
      for (int n = 0; n < 64; n++)
         for (int d = 0; d < 5; d++) tbl[n][d] = d;
      lf = SEED;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy === 1'b0, "R1 busy reset", PW'(busy), PW'(0));
      check(done === 1'b0, "R1 done reset", PW'(done), PW'(0));
      check(path_out === '0, "R1 path reset", path_out, '0);

      send(0, 0, 63, "R4 corner route identity tables");
      // R2: requests while busy are ignored
      req_valid = 1'b1; req_src_x = 3'd5; req_src_y = 3'd5; req_dst_node = 6'd0;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;

      send(7, 7, 0, "R3 west then south");
      send(3, 4, 35, "R5 destination equals source");
      while (busy) @(negedge clk);
      @(negedge clk);

      held = path_out;
      for (int n = 0; n < 8; n++) cfg_write(n);
      for (int y = 1; y < 8; y++) cfg_write(y * 8 + 7);
      cfg_write(9); cfg_write(17); cfg_write(49);
      check(path_out === held, "R8 config leaves path", path_out, held);

      send(0, 0, 63, "R8 corner route permuted tables");
      send(2, 6, 9, "R3 west then south mid mesh");
      send(1, 1, 49, "R3 north only permuted");
      send(7, 0, 63, "R3 north column permuted");
      send(4, 2, 39, "R3 east then north");

      while (exp_q.size() != 0 || busy) @(negedge clk);
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R7 all results seen", PW'(exp_q.size()), '0);
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R7: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule